// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry-in with no clock and no state. The operand width is divided into four 4-bit groups. Each group forms a generate and a propagate term for every bit. It derives all of its internal carries as flat sum-of-products expressions, so no carry passes from bit to bit inside the group. Each group also reports one group generate term and one group propagate term. Neither of these depends on the carry entering the group.

A second lookahead stage uses the same flat expansion on the four group terms and the external carry-in. It produces the carry into each of the upper three groups and the final carry-out. No carry travels from group to group. The worst path is therefore a fixed number of AND-OR levels and does not grow with the number of groups. The operand width and the group size are parameters.

Top module: `lookahead_adder`

## Requirements
- R1: `sum` equals the low 16 bits of `op_a + op_b + carry_in`, with all three taken as unsigned values.
- R2: `carry_out` equals bit 16 of `op_a + op_b + carry_in`.
- R3: With `op_a = 16'hFFFF`, `op_b = 16'h0001` and `carry_in = 0`, the block gives `sum = 16'h0000` and `carry_out = 1`.
- R4: When every bit position propagates (`op_b = ~op_a`), the result is `sum = 16'hFFFF, carry_out = 0` for `carry_in = 0`, and `sum = 16'h0000, carry_out = 1` for `carry_in = 1`.
- R5: A carry produced in a lower group reaches every higher group whose bits all propagate. Group k covers bits 4k+3..4k. For example, `16'h0FF0 + 16'h0010` gives `16'h1000`, and `carry_in = 1` with `op_a = 16'h0FFF` gives `16'h1000`.
- R6: The block is purely combinational. Outputs are valid in the same cycle as the inputs they follow, with no register in the path.
- R7: A carry into one group affects only that group and the groups above it. When `carry_in` toggles and group 0 does not pass the carry through, bits 15..4 of `sum` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
There is no register between any input and either output. `sum` and `carry_out` are both due in the same cycle as the operands that produce them. The bench changes the operands on the falling clock edge and samples a few nanoseconds later, before the next rising edge. Every comparison therefore sees values that have settled from the current stimulus alone. The bench never waits a whole cycle for a result.

// File: rtl/cla_pkg.sv
package cla_pkg;
   // Group-level lookahead terms passed up to the next level
   typedef struct packed {
      logic gen;
      logic prop;
   } gp_t;

   localparam int unsigned DEF_WIDTH = 16;
   localparam int unsigned DEF_GROUP = 4;
endpackage

// File: rtl/cla_sop.sv
// Flat sum-of-products lookahead over N generate/propagate pairs.
module cla_sop #(
   parameter int unsigned N = 4
) (
   input  logic [N-1:0]     gen,
   input  logic [N-1:0]     prop,
   input  logic             cin,
   output logic [N:0]       carry,
   output cla_pkg::gp_t     blk
);
   if (N < 1 || N > 8) begin : g_bad_n
      $error("cla_sop: N must be 1..8");
   end

   // carry[i+1] = OR over j of (g[j] & p[j+1..i]) | (p[0..i] & cin)
   always_comb begin
      carry[0] = cin;
      for (int i = 0; i < N; i++) begin
         logic acc;
         logic term;
         term = cin;
         for (int k = 0; k <= i; k++) term = term & prop[k];
         acc = term;
         for (int j = 0; j <= i; j++) begin
            term = gen[j];
            for (int k = j + 1; k <= i; k++) term = term & prop[k];
            acc = acc | term;
         end
         carry[i+1] = acc;
      end
   end

   // Block terms do not depend on cin
   always_comb begin
      logic acc;
      logic term;
      acc = 1'b0;
      for (int j = 0; j < N; j++) begin
         term = gen[j];
         for (int k = j + 1; k < N; k++) term = term & prop[k];
         acc = acc | term;
      end
      blk.gen  = acc;
      blk.prop = &prop;
   end

   // R5: flat expansion agrees with the bit-serial carry recurrence
   always_comb begin
      for (int i = 0; i < N; i++) begin
         a_r5_recurrence: assert (carry[i+1] == (gen[i] | (prop[i] & carry[i])))
            else $error("cla_sop carry %0d breaks recurrence", i + 1);
      end
   end

   // R7: block terms give the top carry for any cin
   always_comb begin
      a_r7_block_terms: assert (carry[N] == (blk.gen | (blk.prop & cin)))
         else $error("cla_sop block terms disagree with top carry");
   end
endmodule

// File: rtl/cla_group.sv
// One group: bit g/p, lookahead carries, sum bits, group terms.
module cla_group #(
   parameter int unsigned GW = 4
) (
   input  logic [GW-1:0]    a,
   input  logic [GW-1:0]    b,
   input  logic             cin,
   output logic [GW-1:0]    sum,
   output logic             cout_loc,
   output cla_pkg::gp_t     gp
);
   logic [GW-1:0] bit_gen;
   logic [GW-1:0] bit_prop;
   logic [GW:0]   bit_carry;

   assign bit_gen  = a & b;
   assign bit_prop = a | b;

   cla_sop #(.N(GW)) u_bits (
      .gen   (bit_gen),
      .prop  (bit_prop),
      .cin   (cin),
      .carry (bit_carry),
      .blk   (gp)
   );

   assign sum      = a ^ b ^ bit_carry[GW-1:0];
   assign cout_loc = bit_carry[GW];

   // R1: group result matches arithmetic on the group slice
   always_comb begin
      a_r1_group_sum: assert ({cout_loc, sum} == ({1'b0, a} + {1'b0, b} + {{GW{1'b0}}, cin}))
         else $error("cla_group slice sum wrong");
   end
endmodule

// File: rtl/lookahead_adder.sv
// Two-level carry-lookahead adder, top.
module lookahead_adder #(
   parameter int unsigned WIDTH = cla_pkg::DEF_WIDTH,
   parameter int unsigned GROUP = cla_pkg::DEF_GROUP
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   output logic [WIDTH-1:0] sum,
   output logic             carry_out
);
   localparam int unsigned NGRP = WIDTH / GROUP;

   if (GROUP == 0 || (WIDTH % GROUP) != 0) begin : g_bad_split
      $error("lookahead_adder: WIDTH must be a multiple of GROUP");
   end
   if (NGRP > 8) begin : g_bad_count
      $error("lookahead_adder: at most 8 groups for a single second level");
   end

   logic [NGRP-1:0] grp_gen;
   logic [NGRP-1:0] grp_prop;
   logic [NGRP-1:0] grp_cout;
   logic [NGRP:0]   grp_carry;
   cla_pkg::gp_t    top_blk;

   for (genvar k = 0; k < NGRP; k++) begin : g_grp
      cla_pkg::gp_t gp_k;
      cla_group #(.GW(GROUP)) u_grp (
         .a        (op_a[k*GROUP +: GROUP]),
         .b        (op_b[k*GROUP +: GROUP]),
         .cin      (grp_carry[k]),
         .sum      (sum[k*GROUP +: GROUP]),
         .cout_loc (grp_cout[k]),
         .gp       (gp_k)
      );
      assign grp_gen[k]  = gp_k.gen;
      assign grp_prop[k] = gp_k.prop;
   end

   cla_sop #(.N(NGRP)) u_second (
      .gen   (grp_gen),
      .prop  (grp_prop),
      .cin   (carry_in),
      .carry (grp_carry),
      .blk   (top_blk)
   );

   assign carry_out = grp_carry[NGRP];

   // R1 / R2: full-width result equals plain addition
   always_comb begin
      a_r1_sum: assert (sum == WIDTH'(op_a + op_b + WIDTH'(carry_in)))
         else $error("lookahead_adder sum wrong");
      a_r2_cout: assert ({carry_out, sum} ==
                         ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in}))
         else $error("lookahead_adder carry_out wrong");
      a_r7_top_terms: assert (carry_out == (top_blk.gen | (top_blk.prop & carry_in)))
         else $error("lookahead_adder top terms disagree");
   end

   // R5: second-level carry into each group equals the group below's local carry
   always_comb begin
      for (int k = 0; k < NGRP; k++) begin
         a_r5_group_chain: assert (grp_carry[k+1] == grp_cout[k])
            else $error("group %0d carry mismatch", k + 1);
      end
   end
endmodule

// File: tb/lookahead_adder_bench.sv
module lookahead_adder_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         carry_in = 1'b0;
   logic [W-1:0] sum;
   logic         carry_out;

   int n_vec  = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   lookahead_adder u_lookahead_adder (
      .op_a      (op_a),
      .op_b      (op_b),
      .carry_in  (carry_in),
      .sum       (sum),
      .carry_out (carry_out)
   );

   function automatic logic [W:0] ref_add(logic [W-1:0] x, logic [W-1:0] y, logic c);
      return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
   endfunction

   // Drive on falling edge, sample 3 ns later (combinational path).
   task automatic apply(input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
      @(negedge clk);
      op_a = x; op_b = y; carry_in = c;
      #3;
   endtask

   task automatic check(input string req, input logic [W:0] exp_v);
      n_vec++;
      if ({carry_out, sum} !== exp_v) begin
         n_fail++;
         $display("FAIL %s a=%h b=%h cin=%b got=%h expected=%h",
                  req, op_a, op_b, carry_in, {carry_out, sum}, exp_v);
      end
   endtask

   task automatic run(input string req, input logic [W-1:0] x, input logic [W-1:0] y, input logic c);
      apply(x, y, c);
      check(req, ref_add(x, y, c));
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_fail++;
         n_vec++;
         $display("FAIL watchdog got=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] hi_before;
      void'($urandom(32'h5EED_0C1A));
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R6: quiet state, all zero inputs give zero in the same cycle
      apply('0, '0, 1'b0);
      check("R6", 17'h0_0000);

      // R1 R2: exhaustive per group, other groups at zero and at all-propagate
      for (int g = 0; g < 4; g++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               for (int c = 0; c < 2; c++) begin
                  run("R1_R2_group", W'(x) << (4*g), W'(y) << (4*g), 1'(c));
               end
            end
         end
      end
      for (int g = 0; g < 4; g++) begin
         for (int x = 0; x < 16; x++) begin
            for (int y = 0; y < 16; y++) begin
               logic [W-1:0] fill;
               fill = ~(W'(16'hF) << (4*g));
               run("R1_R2_fill", (W'(x) << (4*g)) | fill, W'(y) << (4*g), 1'(y & 1));
            end
         end
      end

      // R3: all ones plus one
      apply(16'hFFFF, 16'h0001, 1'b0);
      check("R3", 17'h1_0000);
      apply(16'hFFFF, 16'h0000, 1'b1);
      check("R3", 17'h1_0000);

      // R4: all-propagate
      apply(16'hA5C3, 16'h5A3C, 1'b0);
      check("R4", 17'h0_FFFF);
      apply(16'hA5C3, 16'h5A3C, 1'b1);
      check("R4", 17'h1_0000);
      apply(16'hFFFF, 16'h0000, 1'b0);
      check("R4", 17'h0_FFFF);

      // R5: carries crossing group boundaries
      apply(16'h0FF0, 16'h0010, 1'b0);
      check("R5", 17'h0_1000);
      apply(16'h0FFF, 16'h0000, 1'b1);
      check("R5", 17'h0_1000);
      apply(16'h00F8, 16'h0008, 1'b0);
      check("R5", 17'h0_0100);
      apply(16'hFFFF, 16'hFFFF, 1'b1);
      check("R5", 17'h1_FFFF);

      // R7: group 0 stops the carry (a=3,b=4), so cin toggles bits 3..0 only
      apply(16'h9AB3, 16'h1234, 1'b0);
      check("R7", ref_add(16'h9AB3, 16'h1234, 1'b0));
      hi_before = sum & 16'hFFF0;
      apply(16'h9AB3, 16'h1234, 1'b1);
      check("R7", ref_add(16'h9AB3, 16'h1234, 1'b1));
      n_vec++;
      if ((sum & 16'hFFF0) !== hi_before) begin
         n_fail++;
         $display("FAIL R7 upper bits got=%h expected=%h", sum & 16'hFFF0, hi_before);
      end

      // R1 R2: constrained random, biased toward propagate-heavy operands
      for (int i = 0; i < 4000; i++) begin
         logic [W-1:0] x;
         logic [W-1:0] y;
         x = W'($urandom);
         y = W'($urandom);
         if (($urandom % 4) == 0) y = ~x ^ W'(16'h1) << ($urandom % 16);
         run("R1_R2_rand", x, y, 1'($urandom));
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule